// File: doc/BRIEF.md
# Longest-match lexer controller

This block sits between a finite-automaton token matcher and the token FIFO that feeds a parser. It steps the matcher through the input one character per cycle, starting at the current token start. While the matcher runs, the controller keeps a record of the most recent report that the current mode allows, together with the character position just after that report. Scanning continues past any report until every matcher bank has run out of live states. At that point the controller emits the token for the recorded report, moves the read position back to just after the recorded match, restarts the matcher with a fresh mode mask, and begins the next token. If no report was recorded, it emits an error token and moves forward by one character.

Every report bit carries a global state number `id = bank*NS + state`. The token for a report is `id + 1`, and the error token is 0. A set bit in the mode mask suppresses the report of that global state for the whole token. The mask is taken from `mode_mask` each time the matcher restarts. The matcher answers combinationally: in a cycle where `feed` is high, `act_vec` and `rpt_vec` describe the matcher state after the character at `feed_pos`.

Control is a four-state machine. IDLE waits for `start`. RESTART pulses `mtch_rst`, latches the mask, clears the report record and either ends the run or goes to SCAN. SCAN feeds characters and detects exhaustion or the end of the input, then goes to EMIT. EMIT pushes the token, moves the read position and returns to RESTART.

Top module: `lex_longest_ctl`

## Requirements
- R1: After reset, `busy`, `feed`, `mtch_rst` and `tok_push` are all low.
- R2: A `start` pulse in IDLE begins lexing at position 0 of `in_len` characters. In SCAN, `feed` carries consecutive positions, one per cycle, and `feed_pos` is always below `in_len`.
- R3: A token ends when a feed cycle sees every bit of `act_vec` at zero. It also ends when the read position reaches `in_len`. A single live bit in any bank keeps scanning going.
- R4: A report bit in `rpt_vec` is recorded only if its bit in the latched mask is clear. A later report overwrites an earlier one. When several bits arrive in the same cycle, the lowest index wins. The longest allowed match is therefore the one emitted.
- R5: With a recorded report of global state `id`, the emitted token is `id + 1`. The next token starts at the position just after the character that produced the report.
- R6: With no recorded report, the emitted token is 0 and the next token starts one character after the failed start.
- R7: The token is pushed in the cycle after the feed cycle that detected exhaustion, unless `tok_full` is high in that cycle.
- R8: While `tok_full` is high, neither `feed` nor `tok_push` is asserted.
- R9: Each push is followed on the next cycle by a `mtch_rst` pulse. A restart at position `in_len` ends the run and drops `busy`. An empty input emits no token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin lexing a new input |
| in_len | input | POS_W | Number of characters in the input |
| mode_mask | input | NB*NS | Report suppression mask, latched at every restart |
| act_vec | input | NB*NS | Matcher live-state vector, all banks |
| rpt_vec | input | NB*NS | Matcher report vector for the fed character |
| tok_full | input | 1 | Token FIFO full |
| feed | output | 1 | Character at `feed_pos` is presented to the matcher |
| feed_pos | output | POS_W | Read position |
| mtch_rst | output | 1 | Restart the matcher for a new token |
| tok_push | output | 1 | Write `tok_data` into the token FIFO |
| tok_data | output | TOK_W | Token code |
| busy | output | 1 | Lexing in progress |

## Verification
The bench builds the block with two banks of eight states and a 12-bit position. Its reports are then spread over both banks, so exhaustion only counts once both banks are dead. The matcher model accepts a small set of nested patterns such as "a", "ab" and "abcd". Some inputs fail only at a later character, which forces rewinds over several characters, and dead prefixes produce error tokens. A random `tok_full` stalls the block in both SCAN and EMIT. Random masks make shorter matches win over suppressed longer ones.

// File: rtl/lex_pkg.sv
package lex_pkg;
    typedef enum logic [1:0] {
        LX_IDLE    = 2'd0,
        LX_RESTART = 2'd1,
        LX_SCAN    = 2'd2,
        LX_EMIT    = 2'd3
    } lx_state_e;
endpackage

// File: rtl/lex_exhaust.sv
module lex_exhaust #(
    parameter int NB = 2,
    parameter int NS = 8
) (
    input  logic [NB*NS-1:0] act_vec,
    output logic             all_dead
);
    logic [NB-1:0] bank_live;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_live[b] = |act_vec[b*NS +: NS];
    end

    assign all_dead = ~|bank_live;
endmodule

// File: rtl/lex_report_pick.sv
module lex_report_pick #(
    parameter int N    = 16,
    parameter int ID_W = 4
) (
    input  logic [N-1:0]    rpt_vec,
    input  logic [N-1:0]    mask,
    output logic            hit,
    output logic [ID_W-1:0] id
);
    logic [N-1:0] allowed;

    assign allowed = rpt_vec & ~mask;

    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (allowed[i]) begin
                hit = 1'b1;
                id  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/lex_tok_map.sv
module lex_tok_map #(
    parameter int ID_W  = 4,
    parameter int TOK_W = 8
) (
    input  logic [ID_W-1:0]  id,
    output logic [TOK_W-1:0] tok
);
    assign tok = TOK_W'(id) + TOK_W'(1);
endmodule

// File: rtl/lex_longest_ctl.sv
module lex_longest_ctl
    import lex_pkg::*;
#(
    parameter int NB    = 2,
    parameter int NS    = 8,
    parameter int POS_W = 32,
    parameter int TOK_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [POS_W-1:0]    in_len,
    input  logic [NB*NS-1:0]    mode_mask,
    input  logic [NB*NS-1:0]    act_vec,
    input  logic [NB*NS-1:0]    rpt_vec,
    input  logic                tok_full,
    output logic                feed,
    output logic [POS_W-1:0]    feed_pos,
    output logic                mtch_rst,
    output logic                tok_push,
    output logic [TOK_W-1:0]    tok_data,
    output logic                busy
);
    localparam int NT   = NB * NS;
    localparam int ID_W = (NT > 1) ? $clog2(NT) : 1;
    localparam logic [TOK_W-1:0] ERR_TOK = '0;

    lx_state_e        state, nxt;
    logic [POS_W-1:0] pos, len_q, tok_start, rec_pos;
    logic [NT-1:0]    mask_q;
    logic             rec_valid;
    logic [ID_W-1:0]  rec_id;

    logic             all_dead, pick_hit, at_end;
    logic [ID_W-1:0]  pick_id;
    logic [TOK_W-1:0] map_tok;

    lex_exhaust #(.NB(NB), .NS(NS)) u_exh (
        .act_vec  (act_vec),
        .all_dead (all_dead)
    );

    lex_report_pick #(.N(NT), .ID_W(ID_W)) u_pick (
        .rpt_vec (rpt_vec),
        .mask    (mask_q),
        .hit     (pick_hit),
        .id      (pick_id)
    );

    lex_tok_map #(.ID_W(ID_W), .TOK_W(TOK_W)) u_map (
        .id  (rec_id),
        .tok (map_tok)
    );

    assign at_end = (pos >= len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LX_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            LX_IDLE:    if (start) nxt = LX_RESTART;
            LX_RESTART: nxt = at_end ? LX_IDLE : LX_SCAN;
            LX_SCAN: begin
                if (at_end)             nxt = LX_EMIT;
                else if (!tok_full && all_dead) nxt = LX_EMIT;
            end
            LX_EMIT:    if (!tok_full) nxt = LX_RESTART;
            default:    nxt = LX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        feed     = (state == LX_SCAN) && !at_end && !tok_full;
        mtch_rst = (state == LX_RESTART);
        tok_push = (state == LX_EMIT) && !tok_full;
        tok_data = rec_valid ? map_tok : ERR_TOK;
        busy     = (state != LX_IDLE);
        feed_pos = pos;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos       <= '0;
            len_q     <= '0;
            tok_start <= '0;
            mask_q    <= '0;
            rec_valid <= 1'b0;
            rec_pos   <= '0;
            rec_id    <= '0;
        end else begin
            if (state == LX_IDLE && start) begin
                pos   <= '0;
                len_q <= in_len;
            end
            if (mtch_rst) begin
                tok_start <= pos;
                mask_q    <= mode_mask;
                rec_valid <= 1'b0;
            end
            if (feed) begin
                pos <= pos + POS_W'(1);
                if (pick_hit) begin
                    rec_valid <= 1'b1;
                    rec_pos   <= pos + POS_W'(1);
                    rec_id    <= pick_id;
                end
            end
            if (tok_push) begin
                pos <= rec_valid ? rec_pos : tok_start + POS_W'(1);
            end
        end
    end
endmodule

// File: rtl/lex_longest_chk.sv
module lex_longest_chk #(
    parameter int NB    = 2,
    parameter int NS    = 8,
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] in_len,
    input logic [NB*NS-1:0] act_vec,
    input logic             tok_full,
    input logic             feed,
    input logic [POS_W-1:0] feed_pos,
    input logic             mtch_rst,
    input logic             tok_push
);
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        tok_full |-> !tok_push);

    a_r8_no_feed_full: assert property (@(posedge clk) disable iff (!rst_n)
        tok_full |-> !feed);

    a_r7_emit_next: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && act_vec == '0) |=> (tok_push || tok_full));

    a_r2_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && $past(feed)) |-> feed_pos == $past(feed_pos) + POS_W'(1));

    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        feed |-> feed_pos < in_len);

    a_r9_restart_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        tok_push |=> mtch_rst);

    a_r9_restart_alone: assert property (@(posedge clk) disable iff (!rst_n)
        mtch_rst |-> !(feed || tok_push));
endmodule

bind lex_longest_ctl lex_longest_chk #(.NB(NB), .NS(NS), .POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_len   (in_len),
    .act_vec  (act_vec),
    .tok_full (tok_full),
    .feed     (feed),
    .feed_pos (feed_pos),
    .mtch_rst (mtch_rst),
    .tok_push (tok_push)
);

// File: tb/sim_lex_longest_ctl.sv
module sim_lex_longest_ctl;
    localparam int NB = 2, NS = 8, POS_W = 12, TOK_W = 8;
    localparam int NT = NB * NS;
    localparam int MAXL = 48;
    localparam int NP = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, start, tok_full;
    logic [POS_W-1:0] in_len;
    logic [NT-1:0]    mode_mask, act_vec, rpt_vec;
    logic             feed, mtch_rst, tok_push, busy;
    logic [POS_W-1:0] feed_pos;
    logic [TOK_W-1:0] tok_data;

    lex_longest_ctl #(.NB(NB), .NS(NS), .POS_W(POS_W), .TOK_W(TOK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_len(in_len),
        .mode_mask(mode_mask), .act_vec(act_vec), .rpt_vec(rpt_vec),
        .tok_full(tok_full), .feed(feed), .feed_pos(feed_pos),
        .mtch_rst(mtch_rst), .tok_push(tok_push), .tok_data(tok_data),
        .busy(busy)
    );

    logic [7:0] cbuf [MAXL];
    string      pats [NP];
    int         pid  [NP];
    int         checks = 0, fails = 0;
    int         cycles = 0;
    int         exp_q[$];
    int         full_pct = 0;
    int         viol_full, viol_rng, viol_lat;
    bit         prev_exh;
    logic [POS_W-1:0] tstart = '0;

    always @(posedge clk) if (mtch_rst) tstart <= feed_pos;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual %0d cycles, expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic logic [NT-1:0] mvec(input int s, input int e, input bit want_rpt);
        logic [NT-1:0] v = '0;
        int n = e - s + 1;
        for (int k = 0; k < NP; k++) begin
            if (n >= 1 && n <= pats[k].len()) begin
                bit ok = 1'b1;
                for (int j = 0; j < n; j++)
                    if (s + j >= MAXL || cbuf[s+j] != pats[k][j]) ok = 1'b0;
                if (ok && (!want_rpt || n == pats[k].len())) v[pid[k]] = 1'b1;
            end
        end
        return v;
    endfunction

    // reference longest-match lexer
    task automatic build_ref(input int len, input logic [NT-1:0] msk);
        int p = 0;
        exp_q.delete();
        while (p < len) begin
            int best = -1, bl = 0;
            for (int k = 0; k < NP; k++) begin
                int l = pats[k].len();
                if (!msk[pid[k]] && p + l <= len && l > bl) begin
                    bit ok = 1'b1;
                    for (int j = 0; j < l; j++) if (cbuf[p+j] != pats[k][j]) ok = 1'b0;
                    if (ok) begin best = k; bl = l; end
                end
            end
            if (best >= 0) begin exp_q.push_back(pid[best] + 1); p += bl; end
            else begin exp_q.push_back(0); p += 1; end
        end
    endtask

    task automatic cycle(input string tag);
        @(negedge clk);
        tok_full = ($urandom_range(99) < full_pct);
        act_vec  = mvec(int'(tstart), int'(feed_pos), 1'b0);
        rpt_vec  = mvec(int'(tstart), int'(feed_pos), 1'b1);
        #1;
        if (tok_full && (feed || tok_push)) viol_full++;
        if (feed && feed_pos >= in_len) viol_rng++;
        if (prev_exh && !(tok_push || tok_full)) viol_lat++;
        if (tok_push) begin
            int e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            string t = (tag != "") ? tag : ((e == 0) ? "R6 error token" : "R5 token code");
            chk(int'(tok_data) == e, t, int'(tok_data), e);
        end
        prev_exh = feed && (act_vec == '0);
    endtask

    task automatic run_case(input int len, input logic [NT-1:0] msk, input int fp, input string tag);
        build_ref(len, msk);
        viol_full = 0; viol_rng = 0; viol_lat = 0; prev_exh = 1'b0;
        in_len    = POS_W'(len);
        mode_mask = msk;
        full_pct  = fp;
        start     = 1'b1;
        cycle(tag);
        start     = 1'b0;
        for (int i = 0; i < 4000 && busy; i++) cycle(tag);
        chk(busy == 1'b0, "R9 run ends with busy low", int'(busy), 0);
        chk(exp_q.size() == 0, "R9 all tokens emitted", exp_q.size(), 0);
        chk(viol_full == 0, "R8 no feed or push while full", viol_full, 0);
        chk(viol_rng == 0, "R2 feed position below length", viol_rng, 0);
        chk(viol_lat == 0, "R7 push one cycle after exhaustion", viol_lat, 0);
        full_pct = 0;
    endtask

    task automatic load(input string s);
        for (int i = 0; i < s.len(); i++) cbuf[i] = s[i];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        pats[0] = "a";  pats[1] = "ab"; pats[2] = "abcd"; pats[3] = "b";
        pats[4] = "bc"; pats[5] = "cc"; pats[6] = "ccc";  pats[7] = "dab";
        for (int k = 0; k < NP; k++) pid[k] = (k * 5 + 3) % NT;
        for (int i = 0; i < MAXL; i++) cbuf[i] = "x";

        rst_n = 1'b0; start = 1'b0; tok_full = 1'b0;
        in_len = '0; mode_mask = '0; act_vec = '0; rpt_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(feed == 1'b0, "R1 feed after reset", int'(feed), 0);
        chk(tok_push == 1'b0, "R1 push after reset", int'(tok_push), 0);
        chk(mtch_rst == 1'b0, "R1 restart after reset", int'(mtch_rst), 0);

        // R9 empty input
        run_case(0, '0, 0, "R9 empty input");
        // R3 rewind after a longer prefix dies
        load("abca");
        run_case(4, '0, 0, "R3 exhaustion and rewind");
        // R6 dead prefix with no report
        load("dxa");
        run_case(3, '0, 0, "R6 error skip");
        // R4 masked longer match falls back
        load("abca");
        run_case(4, NT'(1) << pid[1], 0, "R4 mask suppression");
        // R4 everything masked
        load("abcd");
        run_case(4, '1, 0, "R4 all masked");
        // R5 longest of nested matches, with stalls
        load("abcdccc");
        run_case(7, '0, 40, "R5 longest match");

        for (int r = 0; r < 30; r++) begin
            int len = $urandom_range(40, 1);
            logic [NT-1:0] msk = '0;
            for (int i = 0; i < len; i++) begin
                int c = $urandom_range(9);
                cbuf[i] = (c < 3) ? "a" : (c < 5) ? "b" : (c < 7) ? "c" : (c < 9) ? "d" : "x";
            end
            if ($urandom_range(2) == 0) msk = NT'($urandom);
            run_case(len, msk, $urandom_range(50), "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule